// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Controller

This block is one memory-to-memory DMA channel. Software builds a linked list of five-word descriptors in memory, writes the address of the first one into the next-pointer register and sets the enable bit. The channel then works through the list without further help. For each descriptor it reads all five words, copies the requested bytes one word at a time through a single word-wide memory request port, and sets a per-descriptor end-of-transfer flag. It then follows the link held in word 0. A zero link ends the chain. The channel raises end-of-chain and parks, still enabled. From there software can extend the list in memory and ask the channel to re-read the link of the last descriptor.

Each descriptor word sits at a byte offset from the descriptor base:
- +0x0 holds the link to the next descriptor.
- +0x4 holds the source address.
- +0x8 holds the destination address.
- +0xC holds the byte count.
- +0x10 holds the control word.

The register port is a plain write strobe with a combinational read. Status flags are write-one-to-clear. A single level interrupt output reflects the status flags that are pending.

The sequencer has seven named states:
- IDLE: the channel is disabled.
- FETCH: the channel reads the five descriptor words.
- READ: the channel reads one source word.
- WRITE: the channel writes one destination word.
- DONE: the descriptor is complete.
- PARK: the chain has ended while the channel is still enabled.
- RELINK: the channel re-reads the link word of the current descriptor.

The transitions are:
- IDLE→FETCH happens on enable with a non-zero pointer.
- IDLE→PARK happens on enable with a zero pointer.
- FETCH→READ happens after the fifth word when the count is non-zero and memory-to-memory is enabled.
- FETCH→DONE happens after the fifth word in every other case.
- READ→WRITE happens on each acknowledge.
- WRITE→READ happens while words remain.
- WRITE→DONE happens after the last word.
- DONE→FETCH happens when the link is non-zero.
- DONE→PARK happens when the link is zero.
- PARK→RELINK happens on a pending append.
- RELINK→FETCH happens when the re-read link is non-zero.
- RELINK→PARK happens when the re-read link is zero.
- Any state goes to IDLE when the channel is disabled, as soon as the access in flight finishes.
- Any access state goes to IDLE on a memory error.

Top module: `dmac_chan`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `mem_req` is 0.
- R2: The register map is as follows.
  - Control sits at offset 0x0. Bit 0 is the enable and reads back. Bit 1 is append and always reads 0.
  - Status sits at 0x4.
  - Current-descriptor sits at 0xC and is read-only; writes to it are ignored.
  - Next-descriptor sits at 0x10 and is read/write.
  - Unmapped offsets read 0.
- R3: A descriptor at base B is read as words B+0, B+4, B+8, B+0xC and B+0x10. These hold link, source, destination, byte count and control. The current-descriptor register takes the value B when the fetch of B begins. The link word is copied into the next-descriptor register.
- R4: A descriptor copies ceil(N/4) words, where N is bits [24:0] of the byte count word. Word k is read from source+4k and written to destination+4k. Bits above 24 are ignored. No word outside that range is written.
- R5: A descriptor moves no data when its byte count is 0 or its control bit 6 (memory-to-memory enable) is 0. End-of-transfer is still set in both cases.
- R6: After each descriptor the channel follows a non-zero link. After a zero link it sets end-of-chain (status bit 8) and parks with busy low and the enable still set.
- R7: Status bit 10 reads 1 from the first descriptor fetch until the channel parks or stops. Whenever it reads 0, no memory request is made.
- R8: Status bits 9 (end-of-transfer), 8 (end-of-chain) and 5 (memory error) are cleared only by writing 1 to them. Writing 0 leaves them unchanged.
- R9: `irq` is high while end-of-chain is set, or the memory error is set, or end-of-transfer is set by a descriptor whose control bit 4 is 1. It stays high until software clears that status.
- R10: Writing control bit 1 while enabled makes the parked channel re-read word 0 of the current descriptor. A non-zero value continues the chain from that address. A zero value returns to parking without setting end-of-chain again. Writing bit 1 while disabled is ignored.
- R11: Clearing control bit 0 stops the channel after the access in flight completes. Busy goes to 0 and no further words are copied.
- R12: A memory error response sets status bit 5, clears the enable and stops the channel.
- R13: Enabling the channel while the next-descriptor register holds 0 sets end-of-chain at once and parks without touching memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_err | input | 1 | Error response, valid with mem_ack |
| irq | output | 1 | Level interrupt |

## Verification
The copy path is swept over every byte count from 0 to 20, each with a distinct data pattern and sentinels past the end of the destination. This separates whole-word counts from the round-up cases, and catches off-by-one overruns and the zero-length case.

Separate runs cover several situations:
- A three-descriptor chain, which checks link following and the final register values.
- Descriptors with and without the interrupt-enable bit, which show which status feeds `irq`.
- A count with bits above 24 set.
- Memory-to-memory disabled.
- A zero starting pointer.
- Appends with a new link, with a zero link, and while disabled.
- A mid-transfer disable.
- An injected memory error.

Together these tell the stop, park and error paths apart by what reaches memory and what status remains.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_READ,
        S_WRITE,
        S_DONE,
        S_PARK,
        S_RELINK
    } dmac_state_t;

    // register byte offsets
    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 4;
    localparam int OFS_CUR  = 12;
    localparam int OFS_NEXT = 16;

    // control register bits
    localparam int CB_EN     = 0;
    localparam int CB_APPEND = 1;

    // status register bits
    localparam int SB_ERR  = 5;
    localparam int SB_EOC  = 8;
    localparam int SB_EOT  = 9;
    localparam int SB_BUSY = 10;

    // descriptor control word bits
    localparam int DB_IE  = 4;
    localparam int DB_M2M = 6;

    localparam int DESC_WORDS = 5;

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int RAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           en,
    output logic           append_pulse,
    output logic [AW-1:0]  next_ptr,
    input  logic           load_next,
    input  logic [AW-1:0]  load_val,
    input  logic [AW-1:0]  cur_desc,
    input  logic           busy,
    input  logic           set_eot,
    input  logic           eot_ie,
    input  logic           set_eoc,
    input  logic           set_err,
    output logic           st_eot,
    output logic           st_eoc,
    output logic           st_err,
    output logic           irq
);

    logic wr_ctrl, wr_stat, wr_next;
    logic en_q, eot_q, eoc_q, err_q, eot_irq_q;
    logic [AW-1:0] next_q;
    logic clr_eot, clr_eoc, clr_err;

    assign wr_ctrl = reg_we && (reg_addr == RAW'(OFS_CTRL));
    assign wr_stat = reg_we && (reg_addr == RAW'(OFS_STAT));
    assign wr_next = reg_we && (reg_addr == RAW'(OFS_NEXT));

    assign clr_eot = wr_stat && reg_wdata[SB_EOT];
    assign clr_eoc = wr_stat && reg_wdata[SB_EOC];
    assign clr_err = wr_stat && reg_wdata[SB_ERR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            next_q    <= '0;
            eot_q     <= 1'b0;
            eoc_q     <= 1'b0;
            err_q     <= 1'b0;
            eot_irq_q <= 1'b0;
        end else begin
            if (set_err)
                en_q <= 1'b0;
            else if (wr_ctrl)
                en_q <= reg_wdata[CB_EN];

            if (load_next)
                next_q <= load_val;
            else if (wr_next)
                next_q <= reg_wdata[AW-1:0];

            // a hardware set wins over a software clear in the same cycle
            eot_q     <= set_eot | (eot_q & ~clr_eot);
            eot_irq_q <= (set_eot & eot_ie) | (eot_irq_q & ~clr_eot);
            eoc_q     <= set_eoc | (eoc_q & ~clr_eoc);
            err_q     <= set_err | (err_q & ~clr_err);
        end
    end

    assign en           = en_q;
    assign append_pulse = wr_ctrl && reg_wdata[CB_APPEND];
    assign next_ptr     = next_q;
    assign st_eot       = eot_q;
    assign st_eoc       = eoc_q;
    assign st_err       = err_q;
    assign irq          = eot_irq_q | eoc_q | err_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RAW'(OFS_CTRL): reg_rdata[CB_EN] = en_q;
            RAW'(OFS_STAT): begin
                reg_rdata[SB_BUSY] = busy;
                reg_rdata[SB_EOT]  = eot_q;
                reg_rdata[SB_EOC]  = eoc_q;
                reg_rdata[SB_ERR]  = err_q;
            end
            RAW'(OFS_CUR):  reg_rdata = DW'(cur_desc);
            RAW'(OFS_NEXT): reg_rdata = DW'(next_q);
            default:        reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          append_pulse,
    input  logic [AW-1:0] next_ptr,
    output logic          load_next,
    output logic [AW-1:0] load_val,
    output logic [AW-1:0] cur_desc,
    output logic          busy,
    output logic          set_eot,
    output logic          eot_ie,
    output logic          set_eoc,
    output logic          set_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err
);

    localparam int IW  = $clog2(DESC_WORDS);
    localparam int WLW = CW - 1;

    dmac_state_t state, nxt;

    logic [IW-1:0]  widx;
    logic [AW-1:0]  cur_q, src_q, dst_q;
    logic [WLW-1:0] words_left;
    logic [DW-1:0]  dbuf;
    logic           ctl_ie;
    logic           app_pend;
    logic [CW:0]    wsum;
    logic           good_ack;
    logic           last_word;
    logic           link_nz;

    assign good_ack  = mem_ack && !mem_err;
    assign last_word = (widx == IW'(DESC_WORDS - 1));
    assign link_nz   = (mem_rdata[AW-1:0] != '0);
    assign wsum      = {1'b0, mem_rdata[CW-1:0]} + (CW+1)'(3);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:
                if (en)
                    nxt = (next_ptr == '0) ? S_PARK : S_FETCH;
            S_FETCH:
                if (mem_ack) begin
                    if (mem_err || !en)
                        nxt = S_IDLE;
                    else if (last_word)
                        nxt = (mem_rdata[DB_M2M] && words_left != '0) ? S_READ : S_DONE;
                end
            S_READ:
                if (mem_ack)
                    nxt = (mem_err || !en) ? S_IDLE : S_WRITE;
            S_WRITE:
                if (mem_ack) begin
                    if (mem_err || !en)
                        nxt = S_IDLE;
                    else if (words_left == WLW'(1))
                        nxt = S_DONE;
                    else
                        nxt = S_READ;
                end
            S_DONE:
                if (!en)
                    nxt = S_IDLE;
                else
                    nxt = (next_ptr != '0) ? S_FETCH : S_PARK;
            S_PARK:
                if (!en)
                    nxt = S_IDLE;
                else if (app_pend)
                    nxt = S_RELINK;
            S_RELINK:
                if (mem_ack) begin
                    if (mem_err || !en)
                        nxt = S_IDLE;
                    else
                        nxt = link_nz ? S_FETCH : S_PARK;
                end
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = dbuf;
        busy      = 1'b1;
        set_eot   = 1'b0;
        set_eoc   = 1'b0;
        set_err   = 1'b0;
        load_next = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy    = 1'b0;
                set_eoc = en && (next_ptr == '0);
            end
            S_FETCH: begin
                mem_req   = 1'b1;
                mem_addr  = cur_q + AW'({widx, 2'b00});
                set_err   = mem_ack && mem_err;
                load_next = good_ack && (widx == '0);
            end
            S_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
                set_err  = mem_ack && mem_err;
            end
            S_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_q;
                set_err  = mem_ack && mem_err;
            end
            S_DONE: begin
                set_eot = 1'b1;
                set_eoc = en && (next_ptr == '0);
            end
            S_PARK: begin
                busy = 1'b0;
            end
            S_RELINK: begin
                mem_req   = 1'b1;
                mem_addr  = cur_q;
                set_err   = mem_ack && mem_err;
                load_next = good_ack;
            end
        endcase
    end

    assign load_val = mem_rdata[AW-1:0];
    assign eot_ie   = ctl_ie;
    assign cur_desc = cur_q;

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx       <= '0;
            cur_q      <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            words_left <= '0;
            dbuf       <= '0;
            ctl_ie     <= 1'b0;
            app_pend   <= 1'b0;
        end else begin
            case (state)
                S_IDLE:
                    if (en && next_ptr != '0) begin
                        cur_q <= next_ptr;
                        widx  <= '0;
                    end
                S_FETCH:
                    if (mem_ack) begin
                        widx <= widx + IW'(1);
                        case (widx)
                            IW'(1): src_q      <= mem_rdata[AW-1:0];
                            IW'(2): dst_q      <= mem_rdata[AW-1:0];
                            IW'(3): words_left <= wsum[CW:2];
                            IW'(4): ctl_ie     <= mem_rdata[DB_IE];
                            default: ;
                        endcase
                    end
                S_READ:
                    if (mem_ack)
                        dbuf <= mem_rdata;
                S_WRITE:
                    if (mem_ack) begin
                        src_q      <= src_q + AW'(4);
                        dst_q      <= dst_q + AW'(4);
                        words_left <= words_left - WLW'(1);
                    end
                S_DONE:
                    if (en && next_ptr != '0) begin
                        cur_q <= next_ptr;
                        widx  <= '0;
                    end
                S_RELINK:
                    if (good_ack && link_nz) begin
                        cur_q <= mem_rdata[AW-1:0];
                        widx  <= '0;
                    end
                default: ;
            endcase

            if (state == S_IDLE || (state == S_PARK && app_pend))
                app_pend <= 1'b0;
            if (append_pulse && en && state != S_IDLE)
                app_pend <= 1'b1;
        end
    end

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int RAW = 5,
    parameter int CW  = 25
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    input  logic           mem_err,
    output logic           irq
);

    logic          en, append_pulse, load_next, busy;
    logic          set_eot, eot_ie, set_eoc, set_err;
    logic          st_eot, st_eoc, st_err;
    logic [AW-1:0] next_ptr, load_val, cur_desc;

    dmac_regs #(.AW(AW), .DW(DW), .RAW(RAW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .en           (en),
        .append_pulse (append_pulse),
        .next_ptr     (next_ptr),
        .load_next    (load_next),
        .load_val     (load_val),
        .cur_desc     (cur_desc),
        .busy         (busy),
        .set_eot      (set_eot),
        .eot_ie       (eot_ie),
        .set_eoc      (set_eoc),
        .set_err      (set_err),
        .st_eot       (st_eot),
        .st_eoc       (st_eoc),
        .st_err       (st_err),
        .irq          (irq)
    );

    dmac_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .append_pulse (append_pulse),
        .next_ptr     (next_ptr),
        .load_next    (load_next),
        .load_val     (load_val),
        .cur_desc     (cur_desc),
        .busy         (busy),
        .set_eot      (set_eot),
        .eot_ie       (eot_ie),
        .set_eoc      (set_eoc),
        .set_err      (set_err),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ack      (mem_ack),
        .mem_err      (mem_err)
    );

endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk
    import dmac_pkg::*;
#(
    parameter int RAW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [RAW-1:0] reg_addr,
    input logic           mem_req,
    input logic           mem_ack,
    input logic           irq,
    input logic           busy,
    input logic           en,
    input logic           st_eoc,
    input logic           st_err
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req); // R4

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_we && reg_addr == RAW'(OFS_STAT))) |=> irq); // R9

    AST_EOC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_eoc) |-> !busy); // R6

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_err) |-> (!en && !busy)); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R7

    AST_BUSY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en)); // R11

endmodule

bind dmac_chan dmac_chan_chk #(.RAW(RAW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .irq      (irq),
    .busy     (busy),
    .en       (en),
    .st_eoc   (st_eoc),
    .st_err   (st_err)
);

// File: tb/tb_dmac_chan.sv
module tb_dmac_chan;

    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int RAW = 5;
    localparam int MW  = 256;

    localparam logic [RAW-1:0] A_CTRL = 5'h00;
    localparam logic [RAW-1:0] A_STAT = 5'h04;
    localparam logic [RAW-1:0] A_CUR  = 5'h0C;
    localparam logic [RAW-1:0] A_NEXT = 5'h10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n;
    logic           reg_we;
    logic [RAW-1:0] reg_addr;
    logic [DW-1:0]  reg_wdata, reg_rdata;
    logic           mem_req, mem_we, mem_ack, mem_err, irq;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata;

    logic [DW-1:0] mem [MW];
    logic          bd_we;
    logic [7:0]    bd_idx;
    logic [DW-1:0] bd_dat;
    logic          err_on;
    logic [AW-1:0] err_addr;

    int checks = 0;
    int fails  = 0;

    dmac_chan dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
    );

    wire [7:0] midx = mem_addr[9:2];

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_err   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_err   <= mem_req && !mem_ack && err_on && (mem_addr == err_addr);
            mem_rdata <= mem[midx];
            if (mem_req && !mem_ack && mem_we)
                mem[midx] <= mem_wdata;
        end
        if (bd_we)
            mem[bd_idx] <= bd_dat;
    end

    function automatic logic [DW-1:0] pat(input int seed, input int i);
        return {8'hA5, seed[7:0], i[15:0]};
    endfunction

    function automatic logic [DW-1:0] sent(input int i);
        return {16'hDEAD, i[15:0]};
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [RAW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [RAW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_idx = a[9:2]; bd_dat = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic mk_desc(input logic [AW-1:0] b, input logic [AW-1:0] nx,
                           input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input logic [DW-1:0] cnt, input logic [DW-1:0] ctl);
        poke(b, nx); poke(b + 4, s); poke(b + 8, d); poke(b + 12, cnt); poke(b + 16, ctl);
    endtask

    task automatic fill_src(input logic [AW-1:0] a, input int n, input int seed);
        for (int i = 0; i < n; i++) poke(a + AW'(4 * i), pat(seed, i));
    endtask

    task automatic fill_dst(input logic [AW-1:0] a, input int n);
        for (int i = 0; i < n; i++) poke(a + AW'(4 * i), sent(i));
    endtask

    task automatic chk_dst(input string req, input logic [AW-1:0] a, input int n,
                           input int words, input int seed);
        for (int i = 0; i < n; i++)
            chk(req, mem[a[9:2] + 8'(i)], (i < words) ? pat(seed, i) : sent(i));
    endtask

    task automatic wait_idle();
        logic [DW-1:0] s;
        tick(3);
        for (int k = 0; k < 5000; k++) begin
            rd_reg(A_STAT, s);
            if (!s[10]) break;
        end
    endtask

    task automatic finish_run();
        wr_reg(A_CTRL, 32'h0);
        wr_reg(A_STAT, 32'h320);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        bd_we = 1'b0; bd_idx = '0; bd_dat = '0; err_on = 1'b0; err_addr = '0;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        rd_reg(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd_reg(A_STAT, v); chk("R1 stat", v, 0);
        rd_reg(A_CUR, v);  chk("R1 cur", v, 0);
        rd_reg(A_NEXT, v); chk("R1 next", v, 0);
        chk("R1 irq", DW'(irq), 0);
        chk("R1 mem_req", DW'(mem_req), 0);

        // R4/R5 sweep of byte counts 0..20 with round-up and overrun sentinels
        for (int n = 0; n <= 20; n++) begin
            fill_src(32'h100, 6, n);
            fill_dst(32'h200, 7);
            mk_desc(32'h40, 32'h0, 32'h100, 32'h200, DW'(n), 32'h50);
            wr_reg(A_NEXT, 32'h40);
            wr_reg(A_CTRL, 32'h1);
            wait_idle();
            chk_dst("R4 sweep", 32'h200, 7, (n + 3) / 4, n);
            rd_reg(A_STAT, v); chk("R6 sweep stat", v, 32'h300);
            rd_reg(A_CUR, v);  chk("R3 sweep cur", v, 32'h40);
            rd_reg(A_CTRL, v); chk("R6 still enabled", v, 32'h1);
            chk("R9 sweep irq", DW'(irq), 1);
            finish_run();
            chk("R8 cleared irq", DW'(irq), 0);
        end

        // R2 register access
        wr_reg(A_NEXT, 32'h1234_5670);
        rd_reg(A_NEXT, v); chk("R2 next rw", v, 32'h1234_5670);
        wr_reg(A_CUR, 32'hFFFF_FFFF);
        rd_reg(A_CUR, v);  chk("R2 cur ro", v, 32'h40);
        wr_reg(A_CTRL, 32'h2);
        rd_reg(A_CTRL, v); chk("R2 append reads 0", v, 0);
        rd_reg(5'h08, v);  chk("R2 unmapped", v, 0);

        // R3/R6 three-descriptor chain, no interrupt enable
        fill_src(32'h100, 4, 41); fill_src(32'h120, 4, 42); fill_src(32'h140, 4, 43);
        fill_dst(32'h200, 4); fill_dst(32'h220, 4); fill_dst(32'h240, 4);
        mk_desc(32'h40, 32'h60, 32'h100, 32'h200, 4, 32'h40);
        mk_desc(32'h60, 32'h80, 32'h120, 32'h220, 12, 32'h40);
        mk_desc(32'h80, 32'h0, 32'h140, 32'h240, 8, 32'h40);
        wr_reg(A_NEXT, 32'h40);
        wr_reg(A_CTRL, 32'h1);
        wait_idle();
        chk_dst("R6 chain d0", 32'h200, 4, 1, 41);
        chk_dst("R6 chain d1", 32'h220, 4, 3, 42);
        chk_dst("R6 chain d2", 32'h240, 4, 2, 43);
        rd_reg(A_CUR, v);  chk("R3 chain cur", v, 32'h80);
        rd_reg(A_NEXT, v); chk("R3 chain next", v, 0);
        wr_reg(A_STAT, 32'h0);
        rd_reg(A_STAT, v); chk("R8 write zero keeps", v, 32'h300);
        wr_reg(A_STAT, 32'h100);
        rd_reg(A_STAT, v); chk("R8 clear eoc only", v, 32'h200);
        chk("R9 eot without ie", DW'(irq), 0);
        finish_run();

        // R9 interrupt-enabled descriptor keeps irq after eoc clear
        fill_src(32'h100, 2, 7); fill_dst(32'h200, 3);
        mk_desc(32'h40, 32'h0, 32'h100, 32'h200, 8, 32'h50);
        wr_reg(A_NEXT, 32'h40); wr_reg(A_CTRL, 32'h1);
        wait_idle();
        wr_reg(A_STAT, 32'h100);
        chk("R9 eot with ie", DW'(irq), 1);
        wr_reg(A_STAT, 32'h200);
        chk("R9 eot cleared", DW'(irq), 0);
        finish_run();

        // R5 memory-to-memory disabled
        fill_src(32'h100, 2, 9); fill_dst(32'h200, 3);
        mk_desc(32'h40, 32'h0, 32'h100, 32'h200, 8, 32'h10);
        wr_reg(A_NEXT, 32'h40); wr_reg(A_CTRL, 32'h1);
        wait_idle();
        chk_dst("R5 no m2m", 32'h200, 3, 0, 9);
        rd_reg(A_STAT, v); chk("R5 eot still set", v, 32'h300);
        finish_run();

        // R4 count bits above 24 ignored
        fill_src(32'h100, 3, 11); fill_dst(32'h200, 4);
        mk_desc(32'h40, 32'h0, 32'h100, 32'h200, 32'h0200_0008, 32'h40);
        wr_reg(A_NEXT, 32'h40); wr_reg(A_CTRL, 32'h1);
        wait_idle();
        chk_dst("R4 count mask", 32'h200, 4, 2, 11);
        finish_run();

        // R13 zero starting pointer
        wr_reg(A_NEXT, 32'h0); wr_reg(A_CTRL, 32'h1);
        tick(3);
        rd_reg(A_STAT, v); chk("R13 eoc at once", v, 32'h100);
        chk("R13 irq", DW'(irq), 1);
        chk("R13 no request", DW'(mem_req), 0);
        finish_run();

        // R10 append with new link, then with zero link, then while disabled
        fill_src(32'h100, 2, 21); fill_src(32'h140, 2, 22);
        fill_dst(32'h200, 3); fill_dst(32'h240, 3); fill_dst(32'h280, 3);
        mk_desc(32'h40, 32'h0, 32'h100, 32'h200, 8, 32'h40);
        wr_reg(A_NEXT, 32'h40); wr_reg(A_CTRL, 32'h1);
        wait_idle();
        wr_reg(A_STAT, 32'h320);
        mk_desc(32'h60, 32'h0, 32'h140, 32'h240, 8, 32'h40);
        poke(32'h40, 32'h60);
        wr_reg(A_CTRL, 32'h3);
        wait_idle();
        chk_dst("R10 appended copy", 32'h240, 3, 2, 22);
        rd_reg(A_CUR, v);  chk("R10 cur after append", v, 32'h60);
        rd_reg(A_STAT, v); chk("R10 append stat", v, 32'h300);
        wr_reg(A_STAT, 32'h320);
        wr_reg(A_CTRL, 32'h3);
        wait_idle();
        rd_reg(A_STAT, v); chk("R10 zero link no eoc", v, 0);
        rd_reg(A_CUR, v);  chk("R10 zero link cur", v, 32'h60);
        finish_run();
        mk_desc(32'h80, 32'h0, 32'h140, 32'h280, 8, 32'h40);
        poke(32'h60, 32'h80);
        wr_reg(A_CTRL, 32'h2);
        tick(30);
        rd_reg(A_STAT, v); chk("R10 append ignored when off", v, 0);
        chk_dst("R10 append ignored dst", 32'h280, 3, 0, 0);

        // R7/R11 busy during transfer, then disable mid-copy
        fill_src(32'h100, 16, 31); fill_dst(32'h200, 17);
        mk_desc(32'h40, 32'h0, 32'h100, 32'h200, 64, 32'h50);
        wr_reg(A_NEXT, 32'h40); wr_reg(A_CTRL, 32'h1);
        tick(25);
        rd_reg(A_STAT, v); chk("R7 busy bit", v, 32'h400);
        wr_reg(A_CTRL, 32'h0);
        tick(10);
        rd_reg(A_STAT, v); chk("R11 stopped", v, 0);
        chk("R11 no request", DW'(mem_req), 0);
        chk("R11 tail untouched", mem[8'h80 + 8'd15], sent(15));
        finish_run();

        // R12 memory error on third source read
        fill_src(32'h100, 4, 51); fill_dst(32'h200, 5);
        mk_desc(32'h40, 32'h0, 32'h100, 32'h200, 16, 32'h40);
        err_addr = 32'h108; err_on = 1'b1;
        wr_reg(A_NEXT, 32'h40); wr_reg(A_CTRL, 32'h1);
        wait_idle();
        err_on = 1'b0;
        rd_reg(A_STAT, v); chk("R12 err status", v, 32'h20);
        rd_reg(A_CTRL, v); chk("R12 enable cleared", v, 0);
        chk("R12 irq", DW'(irq), 1);
        chk("R12 word1 copied", mem[8'h81], pat(51, 1));
        chk("R12 word2 not copied", mem[8'h82], sent(2));
        wr_reg(A_STAT, 32'h20);
        rd_reg(A_STAT, v); chk("R8 err cleared", v, 0);
        chk("R9 irq after err clear", DW'(irq), 0);

        summary();
        $finish;
    end

endmodule